// File: doc/BRIEF.md
# PLL Output Frequency Calculator

This block holds the settings of a phase-locked loop with one reference input and three output channels, and works out the frequency each channel would produce, as an integer number of hertz. The oscillator frequency is the reference frequency times a stored multiplier. Each channel divides that frequency by its own divisor. A channel can be switched off, the whole loop can be switched off, and a channel can be marked absent. An absent channel is never recomputed. Any reference prescaler sits upstream, so the reference input is taken as already prescaled.

Settings arrive one at a time on a valid/ready write port. A write that changes a setting starts a recomputation. A change on the reference input also starts one. Recomputation walks the channels in index order and uses a shared sequential divider. While it runs, `busy` is high and `cfg_ready` is low. The source must hold `cfg_valid` and its payload until a cycle in which `cfg_ready` is high, so a write presented during a recomputation is applied once that recomputation ends. When a channel's result differs from the value currently on its output, the output takes the new value and the channel's strobe pulses for one cycle.

Top module: `pll_freq_calc`

## Requirements
- R1: After reset, every channel output is 0, no strobe is high, `busy` is low, `cfg_ready` is high, the loop and all channels are disabled, every channel is present, every divisor is 0, and the multiplier is 8.
- R2: A multiplier write (`cfg_kind`=0) with a value below 8 or above 86 is dropped and the old multiplier is kept. Values from 8 to 86 inclusive are taken.
- R3: A present channel's output is 0 when the loop is off (`cfg_kind`=1, bit 0 of data), when that channel is off (`cfg_kind`=2, bit 0), or when its divisor (`cfg_kind`=4) is 0.
- R4: Otherwise a present channel's output is floor(ref_hz * multiplier / divisor), where the product is truncated to FW bits.
- R5: A channel marked absent (`cfg_kind`=3, bit 0 = 0) keeps its output value and never pulses its strobe, whatever else changes.
- R6: A channel's strobe is high for exactly one cycle, and only in the cycle its output first shows a new value. A recomputation that yields the old value gives no strobe.
- R7: An accepted write whose value equals the stored setting starts no recomputation, so `busy` stays low.
- R8: When `ref_hz` differs from the reference used by the last computation and the block is idle, a recomputation of all present channels starts.
- R9: A per-channel write whose `cfg_chan` is NCH or above is accepted but changes nothing.
- R10: `cfg_ready` is low whenever `busy` is high. A write held during a recomputation is applied after it, and it starts its own recomputation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_hz | input | FW | Reference frequency in hertz |
| cfg_valid | input | 1 | Setting write present |
| cfg_ready | output | 1 | Write accepted in this cycle if valid |
| cfg_kind | input | 3 | 0 multiplier, 1 loop enable, 2 channel enable, 3 channel present, 4 channel divisor |
| cfg_chan | input | CHW | Channel index for kinds 2 to 4 |
| cfg_data | input | DW | Setting value |
| busy | output | 1 | Recomputation in progress |
| ch_hz | output | NCH x FW | Per-channel output frequency |
| ch_upd | output | NCH | Per-channel one-cycle change strobe |

## Verification
The bench uses the default parameters: three channels, a 64-bit frequency path, 32-bit settings, and multiplier limits of 8 and 86. With these values the 2-bit channel field can name an index that does not exist, so the bench can drive a write to a missing channel. A full 64-step division for every channel is also exercised on each recomputation. Multiplier writes just outside each limit, and exactly at each limit, reach both sides of the range check. A write held back during a recomputation shows that the ready signal drops while `busy` is high.

// File: rtl/pll_calc_pkg.sv
package pll_calc_pkg;
  typedef enum logic [2:0] {
    CFG_MULT    = 3'd0,
    CFG_PLL_EN  = 3'd1,
    CFG_CH_EN   = 3'd2,
    CFG_CH_PRES = 3'd3,
    CFG_CH_DIV  = 3'd4
  } cfg_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_VCO,
    ST_CHAN,
    ST_DIVW,
    ST_COMMIT
  } eng_state_e;
endpackage

// File: rtl/pll_cfg_regs.sv
module pll_cfg_regs
  import pll_calc_pkg::*;
#(
  parameter int NCH      = 3,
  parameter int DW       = 32,
  parameter int CHW      = 2,
  parameter int MULT_MIN = 8,
  parameter int MULT_MAX = 86,
  parameter int MULT_RST = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [2:0]              kind,
  input  logic [CHW-1:0]          chan,
  input  logic [DW-1:0]           data,
  output logic [DW-1:0]           mult,
  output logic                    pll_en,
  output logic [NCH-1:0]          ch_en,
  output logic [NCH-1:0]          ch_pres,
  output logic [NCH-1:0][DW-1:0]  ch_div,
  output logic                    changed
);
  logic [NCH-1:0] hit;
  logic [NCH-1:0] ch_chg;
  logic           mult_ok;
  logic           mult_chg;
  logic           en_chg;

  assign mult_ok  = (data >= DW'(MULT_MIN)) && (data <= DW'(MULT_MAX));
  assign mult_chg = wr_en && (kind == CFG_MULT) && mult_ok && (data != mult);
  assign en_chg   = wr_en && (kind == CFG_PLL_EN) && (data[0] != pll_en);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign hit[i] = wr_en && (chan == CHW'(i));

    always_comb begin
      ch_chg[i] = 1'b0;
      if (hit[i]) begin
        case (kind)
          CFG_CH_EN:   ch_chg[i] = (data[0] != ch_en[i]);
          CFG_CH_PRES: ch_chg[i] = (data[0] != ch_pres[i]);
          CFG_CH_DIV:  ch_chg[i] = (data != ch_div[i]);
          default:     ch_chg[i] = 1'b0;
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ch_en[i]   <= 1'b0;
        ch_pres[i] <= 1'b1;
        ch_div[i]  <= '0;
      end else if (ch_chg[i]) begin
        case (kind)
          CFG_CH_EN:   ch_en[i]   <= data[0];
          CFG_CH_PRES: ch_pres[i] <= data[0];
          default:     ch_div[i]  <= data;
        endcase
      end
    end
  end

  assign changed = mult_chg || en_chg || (|ch_chg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mult   <= DW'(MULT_RST);
      pll_en <= 1'b0;
    end else begin
      if (mult_chg) mult <= data;
      if (en_chg)   pll_en <= data[0];
    end
  end
endmodule

// File: rtl/pll_seq_div.sv
module pll_seq_div #(
  parameter int W  = 64,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [W-1:0]  dividend,
  input  logic [DW-1:0] divisor,
  output logic          done,
  output logic [W-1:0]  quot
);
  localparam int CNTW = (W > 1) ? $clog2(W) : 1;

  logic [DW-1:0]   rem_q;
  logic [W-1:0]    quo_q;
  logic [CNTW-1:0] cnt_q;
  logic            run_q;
  logic [DW:0]     shifted;
  logic [DW:0]     trial;
  logic            fits;

  assign shifted = {rem_q, quo_q[W-1]};
  assign fits    = shifted >= {1'b0, divisor};
  assign trial   = fits ? (shifted - {1'b0, divisor}) : shifted;
  assign quot    = quo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      done  <= 1'b0;
    end else if (start) begin
      rem_q <= '0;
      quo_q <= dividend;
      cnt_q <= CNTW'(W - 1);
      run_q <= 1'b1;
      done  <= 1'b0;
    end else if (run_q) begin
      rem_q <= trial[DW-1:0];
      quo_q <= {quo_q[W-2:0], fits};
      if (cnt_q == '0) begin
        run_q <= 1'b0;
        done  <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end else begin
      done <= 1'b0;
    end
  end
endmodule

// File: rtl/pll_chan_engine.sv
module pll_chan_engine
  import pll_calc_pkg::*;
#(
  parameter int NCH = 3,
  parameter int FW  = 64,
  parameter int DW  = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [FW-1:0]           ref_in,
  input  logic [DW-1:0]           mult,
  input  logic                    pll_en,
  input  logic [NCH-1:0]          ch_en,
  input  logic [NCH-1:0]          ch_pres,
  input  logic [NCH-1:0][DW-1:0]  ch_div,
  input  logic                    div_done,
  input  logic [FW-1:0]           div_quot,
  output logic                    div_start,
  output logic [FW-1:0]           div_dividend,
  output logic [DW-1:0]           div_divisor,
  output logic [FW-1:0]           ref_used,
  output logic                    busy,
  output logic [NCH-1:0][FW-1:0]  ch_hz,
  output logic [NCH-1:0]          ch_upd
);
  localparam int IDXW = (NCH > 1) ? $clog2(NCH) : 1;

  eng_state_e     state_q;
  logic [IDXW-1:0] idx_q;
  logic [FW-1:0]  vco_q;
  logic [FW-1:0]  res_q;
  logic           pres_cur;
  logic           gated;
  logic           last;

  assign pres_cur     = ch_pres[idx_q];
  assign gated        = !pll_en || !ch_en[idx_q] || (ch_div[idx_q] == '0);
  assign last         = (idx_q == IDXW'(NCH - 1));
  assign busy         = (state_q != ST_IDLE);
  assign div_start    = (state_q == ST_CHAN) && pres_cur && !gated;
  assign div_dividend = vco_q;
  assign div_divisor  = ch_div[idx_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      vco_q    <= '0;
      res_q    <= '0;
      ref_used <= '0;
      ch_hz    <= '0;
      ch_upd   <= '0;
    end else begin
      ch_upd <= '0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            ref_used <= ref_in;
            state_q  <= ST_VCO;
          end
        end
        ST_VCO: begin
          vco_q   <= ref_used * FW'(mult);
          idx_q   <= '0;
          state_q <= ST_CHAN;
        end
        ST_CHAN: begin
          if (!pres_cur) begin
            if (last) state_q <= ST_IDLE;
            else      idx_q   <= idx_q + 1'b1;
          end else if (gated) begin
            res_q   <= '0;
            state_q <= ST_COMMIT;
          end else begin
            state_q <= ST_DIVW;
          end
        end
        ST_DIVW: begin
          if (div_done) begin
            res_q   <= div_quot;
            state_q <= ST_COMMIT;
          end
        end
        ST_COMMIT: begin
          if (res_q != ch_hz[idx_q]) begin
            ch_hz[idx_q]  <= res_q;
            ch_upd[idx_q] <= 1'b1;
          end
          if (last) begin
            state_q <= ST_IDLE;
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= ST_CHAN;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pll_freq_calc.sv
module pll_freq_calc
  import pll_calc_pkg::*;
#(
  parameter int NCH      = 3,
  parameter int FW       = 64,
  parameter int DW       = 32,
  parameter int CHW      = (NCH > 1) ? $clog2(NCH + 1) : 1,
  parameter int MULT_MIN = 8,
  parameter int MULT_MAX = 86,
  parameter int MULT_RST = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [FW-1:0]          ref_hz,
  input  logic                   cfg_valid,
  output logic                   cfg_ready,
  input  logic [2:0]             cfg_kind,
  input  logic [CHW-1:0]         cfg_chan,
  input  logic [DW-1:0]          cfg_data,
  output logic                   busy,
  output logic [NCH-1:0][FW-1:0] ch_hz,
  output logic [NCH-1:0]         ch_upd
);
  logic [DW-1:0]          mult_w;
  logic                   pll_en_w;
  logic [NCH-1:0]         ch_en_w;
  logic [NCH-1:0]         ch_pres_w;
  logic [NCH-1:0][DW-1:0] ch_div_w;
  logic                   changed_w;
  logic                   accept_w;
  logic                   start_w;
  logic [FW-1:0]          ref_used_w;
  logic                   div_start_w;
  logic                   div_done_w;
  logic [FW-1:0]          div_dividend_w;
  logic [DW-1:0]          div_divisor_w;
  logic [FW-1:0]          div_quot_w;

  assign cfg_ready = !busy;
  assign accept_w  = cfg_valid && cfg_ready;
  assign start_w   = !busy && ((accept_w && changed_w) || (ref_hz != ref_used_w));

  pll_cfg_regs #(
    .NCH(NCH), .DW(DW), .CHW(CHW),
    .MULT_MIN(MULT_MIN), .MULT_MAX(MULT_MAX), .MULT_RST(MULT_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(accept_w), .kind(cfg_kind),
    .chan(cfg_chan), .data(cfg_data), .mult(mult_w), .pll_en(pll_en_w),
    .ch_en(ch_en_w), .ch_pres(ch_pres_w), .ch_div(ch_div_w),
    .changed(changed_w)
  );

  pll_chan_engine #(.NCH(NCH), .FW(FW), .DW(DW)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start_w), .ref_in(ref_hz),
    .mult(mult_w), .pll_en(pll_en_w), .ch_en(ch_en_w), .ch_pres(ch_pres_w),
    .ch_div(ch_div_w), .div_done(div_done_w), .div_quot(div_quot_w),
    .div_start(div_start_w), .div_dividend(div_dividend_w),
    .div_divisor(div_divisor_w), .ref_used(ref_used_w), .busy(busy),
    .ch_hz(ch_hz), .ch_upd(ch_upd)
  );

  pll_seq_div #(.W(FW), .DW(DW)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start_w),
    .dividend(div_dividend_w), .divisor(div_divisor_w),
    .done(div_done_w), .quot(div_quot_w)
  );
endmodule

// File: rtl/pll_freq_calc_chk.sv
module pll_freq_calc_chk #(
  parameter int NCH      = 3,
  parameter int FW       = 64,
  parameter int DW       = 32,
  parameter int MULT_MIN = 8,
  parameter int MULT_MAX = 86
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   busy,
  input logic                   cfg_ready,
  input logic [NCH-1:0][FW-1:0] ch_hz,
  input logic [NCH-1:0]         ch_upd,
  input logic [DW-1:0]          mult,
  input logic                   pll_en,
  input logic [NCH-1:0]         ch_en,
  input logic [NCH-1:0]         ch_pres,
  input logic [NCH-1:0][DW-1:0] ch_div
);
  AST_MULT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (mult >= DW'(MULT_MIN)) && (mult <= DW'(MULT_MAX))); // R2

  AST_NO_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cfg_ready); // R10

  AST_IDLE_OUTPUTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> ($stable(ch_hz) && (ch_upd == '0))); // R6

  AST_ONE_STROBE_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_upd)); // R6

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    AST_STROBE_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      ch_upd[i] |-> (ch_hz[i] != $past(ch_hz[i]))); // R6

    AST_ABSENT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_pres[i] |-> !ch_upd[i]); // R5

    AST_GATED_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_upd[i] && (!pll_en || !ch_en[i] || (ch_div[i] == '0))) |-> (ch_hz[i] == '0)); // R3
  end
endmodule

bind pll_freq_calc pll_freq_calc_chk #(
  .NCH(NCH), .FW(FW), .DW(DW), .MULT_MIN(MULT_MIN), .MULT_MAX(MULT_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .cfg_ready(cfg_ready),
  .ch_hz(ch_hz), .ch_upd(ch_upd), .mult(mult_w), .pll_en(pll_en_w),
  .ch_en(ch_en_w), .ch_pres(ch_pres_w), .ch_div(ch_div_w)
);

// File: tb/pll_freq_calc_tb.sv
module pll_freq_calc_tb;
  localparam int NCH = 3;
  localparam int FW  = 64;
  localparam int DW  = 32;
  localparam int CHW = 2;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic [FW-1:0]          ref_hz = '0;
  logic                   cfg_valid = 1'b0;
  logic                   cfg_ready;
  logic [2:0]             cfg_kind = '0;
  logic [CHW-1:0]         cfg_chan = '0;
  logic [DW-1:0]          cfg_data = '0;
  logic                   busy;
  logic [NCH-1:0][FW-1:0] ch_hz;
  logic [NCH-1:0]         ch_upd;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // behavioural model state
  logic [FW-1:0] m_ref = '0;
  logic [DW-1:0] m_mult = 32'd8;
  bit            m_en = 1'b0;
  bit [NCH-1:0]  m_chen = '0;
  bit [NCH-1:0]  m_pres = '1;
  logic [DW-1:0] m_div [NCH];
  logic [FW-1:0] m_out [NCH];
  bit [NCH-1:0]  m_mask;
  bit            m_busy;

  always #5 clk = ~clk;

  pll_freq_calc u_dut (
    .clk(clk), .rst_n(rst_n), .ref_hz(ref_hz), .cfg_valid(cfg_valid),
    .cfg_ready(cfg_ready), .cfg_kind(cfg_kind), .cfg_chan(cfg_chan),
    .cfg_data(cfg_data), .busy(busy), .ch_hz(ch_hz), .ch_upd(ch_upd)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] m_freq(input int c);
    logic [FW-1:0] vco;
    if (!m_en || !m_chen[c] || m_div[c] == '0) return '0;
    vco = m_ref * FW'(m_mult);
    return vco / FW'(m_div[c]);
  endfunction

  function automatic void m_recompute();
    logic [FW-1:0] v;
    m_mask = '0;
    for (int c = 0; c < NCH; c++) begin
      if (m_pres[c]) begin
        v = m_freq(c);
        if (v != m_out[c]) m_mask[c] = 1'b1;
        m_out[c] = v;
      end
    end
  endfunction

  function automatic bit m_apply(input int kind, input int ch, input logic [DW-1:0] d);
    case (kind)
      0: if (d >= 8 && d <= 86 && d != m_mult) begin m_mult = d; return 1; end
      1: if (d[0] != m_en) begin m_en = d[0]; return 1; end
      2: if (ch < NCH && d[0] != m_chen[ch]) begin m_chen[ch] = d[0]; return 1; end
      3: if (ch < NCH && d[0] != m_pres[ch]) begin m_pres[ch] = d[0]; return 1; end
      4: if (ch < NCH && d != m_div[ch]) begin m_div[ch] = d; return 1; end
      default: ;
    endcase
    return 0;
  endfunction

  // drive one write; returns 1 if ready was low when first offered
  task automatic send(input int kind, input int ch, input logic [DW-1:0] d, output bit waited);
    @(negedge clk);
    cfg_valid = 1'b1;
    cfg_kind  = 3'(kind);
    cfg_chan  = CHW'(ch);
    cfg_data  = d;
    waited    = !cfg_ready;
    while (!cfg_ready) @(negedge clk);
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  // wait for idle, then compare against the model
  task automatic settle(input string tag, input bit chk_mask);
    bit [NCH-1:0] seen = '0;
    bit           bsy = 1'b0;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      seen |= ch_upd;
      bsy  |= busy;
    end
    while (busy) begin
      @(negedge clk);
      seen |= ch_upd;
      bsy  |= busy;
    end
    if (chk_mask) begin
      chk({tag, " busy"}, FW'(bsy), FW'(m_busy));
      chk({tag, " strobes R6"}, FW'(seen), FW'(m_mask));
    end
    for (int c = 0; c < NCH; c++) chk({tag, " output"}, ch_hz[c], m_out[c]);
  endtask

  task automatic op(input string tag, input int kind, input int ch, input logic [DW-1:0] d);
    bit w;
    m_busy = m_apply(kind, ch, d);
    if (m_busy) m_recompute(); else m_mask = '0;
    send(kind, ch, d, w);
    settle(tag, 1'b1);
  endtask

  task automatic set_ref(input string tag, input logic [FW-1:0] r);
    @(negedge clk);
    ref_hz = r;
    m_busy = (r != m_ref);
    m_ref  = r;
    if (m_busy) m_recompute(); else m_mask = '0;
    settle(tag, 1'b1);
  endtask

  initial begin
    bit w1, w2;
    for (int c = 0; c < NCH; c++) begin m_div[c] = '0; m_out[c] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int c = 0; c < NCH; c++) chk("R1 reset output", ch_hz[c], '0);
    chk("R1 reset strobes", FW'(ch_upd), '0);
    chk("R1 reset busy", FW'(busy), '0);
    chk("R1 reset ready", FW'(cfg_ready), 64'd1);

    set_ref("R8 ref change, all off", 64'd1_000_000);
    op("R2 mult 7 rejected", 0, 0, 32'd7);
    op("R3 loop on, channels off", 1, 0, 32'd1);
    op("R3 div0", 4, 0, 32'd2);
    op("R3 div1", 4, 1, 32'd3);
    op("R1 ch0 on uses reset mult", 2, 0, 32'd1);
    op("R4 ch1 on, truncating divide", 2, 1, 32'd1);
    op("R3 ch2 on with divisor 0, no change", 2, 2, 32'd1);
    op("R4 ch2 divisor 7", 4, 2, 32'd7);
    op("R2 mult 87 rejected", 0, 0, 32'd87);
    op("R2 mult 86 taken", 0, 0, 32'd86);
    op("R2 mult 8 taken", 0, 0, 32'd8);
    op("R7 same divisor write", 4, 0, 32'd2);
    op("R7 same enable write", 1, 0, 32'd1);
    op("R9 channel 3 write ignored", 4, 3, 32'd5);
    op("R9 channel 3 enable ignored", 2, 3, 32'd0);
    op("R5 ch1 absent", 3, 1, 32'd0);
    op("R5 mult 10 with ch1 absent", 0, 0, 32'd10);
    set_ref("R8 R5 ref odd value", 64'd12_345_677);
    op("R3 ch0 off", 2, 0, 32'd0);
    op("R5 ch1 present again", 3, 1, 32'd1);
    set_ref("R4 large ref", 64'd48_000_000_000);
    op("R4 ch0 on at large ref", 2, 0, 32'd1);

    // R10 back-pressure: second write offered while first recomputes
    m_busy = m_apply(4, 2, 32'd9);
    void'(m_apply(4, 1, 32'd5));
    m_recompute();
    send(4, 2, 32'd9, w1);
    send(4, 1, 32'd5, w2);
    chk("R10 ready low while busy", FW'(w2), 64'd1);
    settle("R10 held write applied", 1'b0);

    op("R3 loop off zeroes all", 1, 0, 32'd0);
    set_ref("R6 ref change with loop off, no strobe", 64'd7);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule